// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This core keeps time for a low-power domain. A 47-bit counter advances once per 32.768 kHz tick strobe. The upper 32 bits count whole seconds and the lower 15 bits hold the fraction of the current second. Software reaches the core through 32-bit word registers. These cover the two halves of the time value, the two halves of an alarm compare value, a run control, a status word and an interrupt mask. One interrupt line is the OR of the status flags that are unmasked.

The core comes out of reset marked invalid, and software must clear that mark before it can load the time or the alarm. The counter does not move until its seconds word has been written at least once, even when the run bit is set. A seconds write made while the counter runs is held back and applied on the next tick. The status flags are cleared by writing ones to them. The alarm flag is sticky and records the tick on which the counter reached the alarm value. A violation event input raises a separate status flag.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the seconds and fraction words read 0, the alarm seconds word reads 0xFFFFFFFF, the alarm fraction word reads 0, the control word at 0x10 and the mask at 0x18 read 0, the status word at 0x14 reads 0x2 (only the invalid flag set), and irq is low.
- R2: While the invalid flag (status bit 1) is set, writes to 0x00, 0x04, 0x08 and 0x0C leave those registers unchanged. Writing 1 to status bit 1 clears the invalid flag.
- R3: The counter keeps its value on every tick until the seconds word (0x00) has been written once after reset, even when the run bit (bit 3 of 0x10) is set.
- R4: Once started, the 47-bit value {seconds, fraction} increases by one on each cycle with tick high, and only while bit 3 of 0x10 is set. Otherwise it holds.
- R5: The 15-bit fraction (0x04, bits 14:0) wraps from 0x7FFF to 0 and carries into the seconds word. The full value wraps from all ones to zero.
- R6: A seconds write while the counter runs leaves the seconds word unchanged until the next counting tick. On that tick the seconds take the written value and the fraction still advances by one without carry. A seconds write while stopped loads at once.
- R7: A write to the fraction word loads bits 14:0 at once, whether or not the counter runs, and leaves the seconds word alone.
- R8: The alarm flag (status bit 4) is set on the tick that brings the 47-bit counter equal to {alarm seconds at 0x08, alarm fraction at 0x0C bits 14:0}. It stays set as the counter moves on, until it is cleared.
- R9: While the alarm seconds word is 0xFFFFFFFF the alarm is disarmed, and no tick sets the alarm flag.
- R10: Writing 0x14 clears each of status bits 4, 1 and 0 whose write-data bit is 1 and leaves the others unchanged. A set event in the same cycle wins over the clear.
- R11: A high cycle on viol_evt sets the violation flag (status bit 0).
- R12: irq is high exactly when some status bit among 4, 1 and 0 is set and the same bit is set in the mask at 0x18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 32.768 kHz |
| viol_evt | input | 1 | Violation event, sets status bit 0 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word, combinational |
| irq | output | 1 | Interrupt: OR of unmasked status flags |

## Verification
The assertions check on every cycle that the counter holds without a tick or a write, and that it stays frozen before its first seconds write. They also check that the alarm flag stays set unless cleared and that a disarmed alarm never raises it. Further cycle checks cover the alarm word being locked while the invalid flag is up, the violation input setting its flag, and irq staying low under an all-zero mask. Only the bench scenarios can show exact counter values: the carry at 0x7FFF, the wrap of the full value, the deferred seconds load landing on the next tick, and the alarm flag rising on the tick of the match. The same holds for priority of a set over a same-cycle clear and for irq following individual mask bits.

// File: rtl/rtc_pkg.sv
// Package: shared constants of the seconds-counter RTC.
// Assumes byte addressing of 32-bit words; offsets are fixed by the register map.
package rtc_pkg;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_SEC      = 8'h00;
    localparam logic [7:0] OFS_FRAC     = 8'h04;
    localparam logic [7:0] OFS_ALM_SEC  = 8'h08;
    localparam logic [7:0] OFS_ALM_FRAC = 8'h0C;
    localparam logic [7:0] OFS_CTRL     = 8'h10;
    localparam logic [7:0] OFS_STAT     = 8'h14;
    localparam logic [7:0] OFS_IEN      = 8'h18;

    localparam int CTRL_RUN_BIT   = 3;
    localparam int ST_ALARM_BIT   = 4;
    localparam int ST_INVALID_BIT = 1;
    localparam int ST_VIOL_BIT    = 0;
endpackage

// File: rtl/rtc_time_counter.sv
// Module: the {seconds, fraction} time counter.
// Counts one step per tick while run_en is set and a seconds write has happened
// since reset. A seconds write while running is parked and applied on the next
// counting tick; a fraction write loads at once. Writes win over a same-cycle tick.
module rtc_time_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    localparam int CNT_W = SEC_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run_en,
    input  logic              sec_we,
    input  logic              frac_we,
    input  logic [SEC_W-1:0]  sec_val,
    input  logic [FRAC_W-1:0] frac_val,
    output logic [SEC_W-1:0]  sec_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              started_q,
    output logic              adv,
    output logic [CNT_W-1:0]  cnt_nxt
);
    logic [SEC_W-1:0] pend_q;
    logic             pend_v;
    logic             running;

    assign running = run_en & started_q;
    assign adv     = tick & running;

    // Value the counter takes on the next counting tick.
    always_comb begin
        if (pend_v) cnt_nxt = {pend_q, frac_q + FRAC_W'(1)};
        else        cnt_nxt = {sec_q, frac_q} + CNT_W'(1);
    end

    // Counter state, parked seconds value and start latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q     <= '0;
            frac_q    <= '0;
            pend_q    <= '0;
            pend_v    <= 1'b0;
            started_q <= 1'b0;
        end else begin
            if (adv) begin
                sec_q  <= cnt_nxt[CNT_W-1:FRAC_W];
                frac_q <= cnt_nxt[FRAC_W-1:0];
                pend_v <= 1'b0;
            end
            if (sec_we) begin
                started_q <= 1'b1;
                if (running) begin
                    pend_q <= sec_val;
                    pend_v <= 1'b1;
                end else begin
                    sec_q  <= sec_val;
                    pend_v <= 1'b0;
                end
            end
            if (frac_we) frac_q <= frac_val;
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Module: alarm compare value and match detector.
// Assumes the counter publishes the value it steps to; a hit is flagged on the
// same edge the counter lands on the alarm. All-ones alarm seconds disarm it.
module rtc_alarm_match #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    localparam int CNT_W = SEC_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_we,
    input  logic              frac_we,
    input  logic [SEC_W-1:0]  sec_val,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic              adv,
    input  logic [CNT_W-1:0]  cnt_nxt,
    output logic [SEC_W-1:0]  alm_sec_q,
    output logic [FRAC_W-1:0] alm_frac_q,
    output logic              hit
);
    logic armed;

    assign armed = ~(&alm_sec_q);
    assign hit   = adv & armed & (cnt_nxt == {alm_sec_q, alm_frac_q});

    // Alarm compare registers, reset to the disarmed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_sec_q  <= '1;
            alm_frac_q <= '0;
        end else begin
            if (sec_we)  alm_sec_q  <= sec_val;
            if (frac_we) alm_frac_q <= frac_val;
        end
    end
endmodule

// File: rtl/rtc_status_irq.sv
// Module: status flags (alarm, invalid, violation) and the interrupt OR.
// Flags clear when written with one; a set event in the same cycle wins.
// Bit order of the 3-bit vectors: [2]=alarm, [1]=invalid, [0]=violation.
module rtc_status_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       viol_evt,
    input  logic       clr_we,
    input  logic [2:0] clr_bits,
    input  logic [2:0] ien,
    output logic [2:0] flags_q,
    output logic       irq
);
    logic [2:0] clr;

    assign clr = clr_we ? clr_bits : 3'b000;
    assign irq = |(flags_q & ien);

    // Sticky flags; the invalid flag is raised by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 3'b010;
        end else begin
            flags_q[2] <= (flags_q[2] & ~clr[2]) | hit;
            flags_q[1] <=  flags_q[1] & ~clr[1];
            flags_q[0] <= (flags_q[0] & ~clr[0]) | viol_evt;
        end
    end
endmodule

// File: rtl/rtc_seconds_core.sv
// Module: top of the seconds-counter RTC with alarm.
// Decodes single-cycle word writes, locks time and alarm writes while the
// invalid flag is up, and returns the addressed word combinationally.
// Assumes tick is a one-cycle strobe synchronous to clk.
module rtc_seconds_core #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      viol_evt,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [rtc_pkg::DATA_W-1:0] wdata,
    output logic [rtc_pkg::DATA_W-1:0] rdata,
    output logic                      irq
);
    import rtc_pkg::*;
    localparam int CNT_W = SEC_W + FRAC_W;

    logic [SEC_W-1:0]  sec_q, alm_sec_q;
    logic [FRAC_W-1:0] frac_q, alm_frac_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              started_q, adv, hit;
    logic              run_q;
    logic [2:0]        ien_q, flags_q;
    logic              caf, nvf, svf;
    logic              unlocked;
    logic              we_sec, we_frac, we_asec, we_afrac, we_ctrl, we_stat, we_ien;

    assign caf = flags_q[2];
    assign nvf = flags_q[1];
    assign svf = flags_q[0];
    assign unlocked = ~nvf;

    assign we_sec   = wr_en & unlocked & (addr == ADDR_W'(OFS_SEC));
    assign we_frac  = wr_en & unlocked & (addr == ADDR_W'(OFS_FRAC));
    assign we_asec  = wr_en & unlocked & (addr == ADDR_W'(OFS_ALM_SEC));
    assign we_afrac = wr_en & unlocked & (addr == ADDR_W'(OFS_ALM_FRAC));
    assign we_ctrl  = wr_en & (addr == ADDR_W'(OFS_CTRL));
    assign we_stat  = wr_en & (addr == ADDR_W'(OFS_STAT));
    assign we_ien   = wr_en & (addr == ADDR_W'(OFS_IEN));

    rtc_time_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_q),
        .sec_we(we_sec), .frac_we(we_frac),
        .sec_val(wdata[SEC_W-1:0]), .frac_val(wdata[FRAC_W-1:0]),
        .sec_q(sec_q), .frac_q(frac_q), .started_q(started_q),
        .adv(adv), .cnt_nxt(cnt_nxt)
    );

    rtc_alarm_match #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_alm (
        .clk(clk), .rst_n(rst_n),
        .sec_we(we_asec), .frac_we(we_afrac),
        .sec_val(wdata[SEC_W-1:0]), .frac_val(wdata[FRAC_W-1:0]),
        .adv(adv), .cnt_nxt(cnt_nxt),
        .alm_sec_q(alm_sec_q), .alm_frac_q(alm_frac_q), .hit(hit)
    );

    rtc_status_irq u_st (
        .clk(clk), .rst_n(rst_n), .hit(hit), .viol_evt(viol_evt),
        .clr_we(we_stat),
        .clr_bits({wdata[ST_ALARM_BIT], wdata[ST_INVALID_BIT], wdata[ST_VIOL_BIT]}),
        .ien(ien_q), .flags_q(flags_q), .irq(irq)
    );

    // Run bit and interrupt mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ien_q <= 3'b000;
        end else begin
            if (we_ctrl) run_q <= wdata[CTRL_RUN_BIT];
            if (we_ien)  ien_q <= {wdata[ST_ALARM_BIT], wdata[ST_INVALID_BIT], wdata[ST_VIOL_BIT]};
        end
    end

    // Read multiplexer for the addressed word.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_SEC):      rdata[SEC_W-1:0]  = sec_q;
            ADDR_W'(OFS_FRAC):     rdata[FRAC_W-1:0] = frac_q;
            ADDR_W'(OFS_ALM_SEC):  rdata[SEC_W-1:0]  = alm_sec_q;
            ADDR_W'(OFS_ALM_FRAC): rdata[FRAC_W-1:0] = alm_frac_q;
            ADDR_W'(OFS_CTRL):     rdata[CTRL_RUN_BIT] = run_q;
            ADDR_W'(OFS_STAT): begin
                rdata[ST_ALARM_BIT]   = caf;
                rdata[ST_INVALID_BIT] = nvf;
                rdata[ST_VIOL_BIT]    = svf;
            end
            ADDR_W'(OFS_IEN): begin
                rdata[ST_ALARM_BIT]   = ien_q[2];
                rdata[ST_INVALID_BIT] = ien_q[1];
                rdata[ST_VIOL_BIT]    = ien_q[0];
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_seconds_core_chk.sv
// Module: property checker for rtc_seconds_core, attached by bind.
// Assumes signals are sampled at the rising clock edge after reset release.
module rtc_seconds_core_chk #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic              viol_evt,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              irq,
    input logic [SEC_W-1:0]  sec_q,
    input logic [FRAC_W-1:0] frac_q,
    input logic [SEC_W-1:0]  alm_sec_q,
    input logic              started_q,
    input logic              caf,
    input logic              nvf,
    input logic              svf,
    input logic [2:0]        ien_q
);
    import rtc_pkg::*;

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(sec_q) && $stable(frac_q)));

    assert_frozen_unstarted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!started_q && !wr_en) |=> ($stable(sec_q) && $stable(frac_q)));

    assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (caf && !(wr_en && addr == ADDR_W'(OFS_STAT) && wdata[ST_ALARM_BIT])) |=> caf);

    assert_disarmed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((&alm_sec_q) && !caf) |=> !caf);

    assert_locked_alarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nvf && wr_en && addr == ADDR_W'(OFS_ALM_SEC)) |=> $stable(alm_sec_q));

    assert_viol_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_evt |=> svf);

    assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 3'b000) |-> !irq);
endmodule

bind rtc_seconds_core rtc_seconds_core_chk #(
    .SEC_W(SEC_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .viol_evt(viol_evt),
    .addr(addr), .wdata(wdata), .irq(irq),
    .sec_q(sec_q), .frac_q(frac_q), .alm_sec_q(alm_sec_q), .started_q(started_q),
    .caf(caf), .nvf(nvf), .svf(svf), .ien_q(ien_q)
);

// File: tb/test_rtc_seconds_core.sv
// Bench: scoreboard style. Driver tasks queue expected values; a monitor at the
// falling edge pops and compares them against the design's outputs.
`timescale 1ns/1ps
module test_rtc_seconds_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        viol_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] q_exp[$];
    string       q_tag[$];
    bit          q_irq[$];

    always #2.5 clk = ~clk;

    rtc_seconds_core i_rtc_seconds_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .viol_evt(viol_evt),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Monitor: compare the head of the scoreboard with the sampled output.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [31:0] exp_v, act_v;
            string tag;
            bit is_irq;
            exp_v  = q_exp.pop_front();
            tag    = q_tag.pop_front();
            is_irq = q_irq.pop_front();
            act_v  = is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act_v !== exp_v) begin
                failures++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act_v, exp_v);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        tick = 1'b0; viol_evt = 1'b0; addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b0; tick = 1'b1;
        end
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic chk(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0; viol_evt = 1'b0; addr = a;
        q_exp.push_back(e); q_tag.push_back(tag); q_irq.push_back(1'b0);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0; viol_evt = 1'b0;
        q_exp.push_back({31'b0, e}); q_tag.push_back(tag); q_irq.push_back(1'b1);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        chk(5'h00, 32'h0, "R1 seconds");
        chk(5'h04, 32'h0, "R1 fraction");
        chk(5'h08, 32'hFFFF_FFFF, "R1 alarm seconds");
        chk(5'h0C, 32'h0, "R1 alarm fraction");
        chk(5'h10, 32'h0, "R1 control");
        chk(5'h14, 32'h2, "R1 status");
        chk(5'h18, 32'h0, "R1 mask");
        chk_irq(1'b0, "R1 irq");

        // R2: locked while invalid
        wr(5'h00, 32'd5);
        wr(5'h04, 32'd9);
        wr(5'h08, 32'd7);
        wr(5'h0C, 32'd3);
        chk(5'h00, 32'h0, "R2 seconds locked");
        chk(5'h04, 32'h0, "R2 fraction locked");
        chk(5'h08, 32'hFFFF_FFFF, "R2 alarm seconds locked");
        chk(5'h0C, 32'h0, "R2 alarm fraction locked");
        wr(5'h18, 32'h2);
        chk_irq(1'b1, "R12 invalid unmasked");
        wr(5'h14, 32'h2);
        chk(5'h14, 32'h0, "R2 invalid cleared");
        chk_irq(1'b0, "R12 no flag");

        // R3: frozen until first seconds write
        wr(5'h10, 32'h8);
        ticks(5);
        chk(5'h04, 32'h0, "R3 frozen before seconds write");
        wr(5'h00, 32'd100);
        chk(5'h00, 32'd100, "R6 stopped load immediate");
        ticks(3);
        chk(5'h04, 32'd3, "R4 counts per tick");

        // R4: run bit clear holds
        wr(5'h10, 32'h0);
        ticks(4);
        chk(5'h04, 32'd3, "R4 hold when stopped");
        wr(5'h10, 32'h8);

        // R7 and R5: fraction load and carry
        wr(5'h04, 32'h7FFE);
        chk(5'h04, 32'h7FFE, "R7 fraction load");
        chk(5'h00, 32'd100, "R7 seconds untouched");
        ticks(2);
        chk(5'h00, 32'd101, "R5 carry into seconds");
        chk(5'h04, 32'h0, "R5 fraction wrap");

        // R6: deferred seconds load while running
        wr(5'h00, 32'd500);
        chk(5'h00, 32'd101, "R6 deferred before tick");
        ticks(1);
        chk(5'h00, 32'd500, "R6 loaded on tick");
        chk(5'h04, 32'd1, "R6 fraction advanced");
        wr(5'h10, 32'h0);
        wr(5'h00, 32'd600);
        chk(5'h00, 32'd600, "R6 immediate while stopped");
        wr(5'h10, 32'h8);

        // R5: full wrap
        wr(5'h00, 32'hFFFF_FFFF);
        ticks(1);
        chk(5'h04, 32'd2, "R6 fraction after deferred load");
        wr(5'h04, 32'h7FFF);
        ticks(1);
        chk(5'h00, 32'h0, "R5 full wrap seconds");
        chk(5'h04, 32'h0, "R5 full wrap fraction");

        // R8: alarm match and sticky flag
        wr(5'h0C, 32'd3);
        wr(5'h08, 32'd0);
        wr(5'h18, 32'h10);
        ticks(2);
        chk(5'h14, 32'h0, "R8 no flag before match");
        chk_irq(1'b0, "R12 irq before match");
        ticks(1);
        chk(5'h14, 32'h10, "R8 flag on match");
        chk_irq(1'b1, "R12 alarm irq");
        ticks(2);
        chk(5'h14, 32'h10, "R8 flag sticky");
        wr(5'h14, 32'h0);
        chk(5'h14, 32'h10, "R10 zero write no effect");
        wr(5'h14, 32'h10);
        chk(5'h14, 32'h0, "R10 alarm cleared");
        chk_irq(1'b0, "R12 irq after clear");

        // R9: disarmed alarm
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'd5);
        wr(5'h10, 32'h0);
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'd4);
        wr(5'h10, 32'h8);
        ticks(1);
        chk(5'h04, 32'd5, "R9 counter reached alarm value");
        chk(5'h14, 32'h0, "R9 disarmed no flag");

        // R11 and R12: violation flag and masking
        @(posedge clk); #1 viol_evt = 1'b1;
        @(posedge clk); #1 viol_evt = 1'b0;
        chk(5'h14, 32'h1, "R11 violation flag");
        chk_irq(1'b0, "R12 violation masked");
        wr(5'h18, 32'h11);
        chk_irq(1'b1, "R12 violation unmasked");
        wr(5'h14, 32'h1);
        chk(5'h14, 32'h0, "R10 violation cleared");
        chk_irq(1'b0, "R12 irq low after clear");

        // R10: set wins over same-cycle clear
        @(posedge clk); #1;
        addr = 5'h14; wdata = 32'h1; wr_en = 1'b1; viol_evt = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; viol_evt = 1'b0;
        chk(5'h14, 32'h1, "R10 set wins over clear");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule